// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Fetch presents a branch address on the lookup port. In the same cycle the block returns three things: the final direction guess, the guesses of its two component predictors, and a snapshot of the global outcome history it used. The two components are a simple table of two-bit counters indexed by address bits and a correlated table indexed by address bits XORed with the global history. A third table, also indexed by address bits, holds one two-bit selector per entry. The selector picks which component's guess becomes the final answer.

When the branch resolves, the pipeline presents four things on the update port: the branch address, the history snapshot taken at lookup, the actual outcome, and the two component guesses that were returned. The block then trains both components and shifts the outcome into the history. A selector moves only when exactly one component guessed right. Every branch starts out trusting the simple table, and it is handed to the correlated table only after that table has proven better on it. All table sizes and the history length are parameters.

Top module: `tourn_bp`

## Requirements
- R1: Each counter is a two-bit value. The encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken and 3 strongly taken. A counter predicts taken when its value is 2 or 3. A valid update moves a counter up by one on a taken outcome and down by one on a not-taken outcome.
- R2: Counters saturate: an increment at 3 leaves 3, and a decrement at 0 leaves 0. From a strong state, two opposite outcomes in a row are needed before the prediction flips.
- R3: The simple table is indexed by address bits `[BIM_IDX_W+1:2]` and carries no tag. Addresses that share those bits share the same counter.
- R4: The correlated table is indexed by address bits `[COR_IDX_W+1:2]` XOR the history, with the history zero-extended to the index width. Lookup uses the current history. Update uses `upd_hist`.
- R5: On each valid update, the history shifts left by one bit and takes the actual outcome into bit 0 (1 = taken). `lkp_hist` shows the current history.
- R6: The selector counter at address bits `[CHO_IDX_W+1:2]` picks the correlated guess when it is 2 or 3, and the simple guess otherwise. `lkp_taken` equals the picked guess.
- R7: On a valid update, the selector changes only when `upd_bim_pred` and `upd_cor_pred` differ. It steps toward the correlated side (+1, saturating) when `upd_cor_pred` matches the outcome, and toward the simple side (-1, saturating) otherwise.
- R8: After reset, every component counter is 1, every selector is 1 (simple side), and the history is 0.
- R9: Lookup is combinational. An update takes effect at the next rising edge, so a lookup in the same cycle as an update returns the values from before that update.
- R10: Both component tables train on every valid update, whichever component the selector favoured.
- R11: While `upd_valid` is low, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| lkp_pc | input | PC_W | Address of the branch being fetched |
| lkp_taken | output | 1 | Final direction guess (1 = taken) |
| lkp_bim_taken | output | 1 | Guess of the simple table |
| lkp_cor_taken | output | 1 | Guess of the correlated table |
| lkp_hist | output | HIST_W | History used for this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned at its lookup |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_bim_pred | input | 1 | Simple-table guess returned at lookup |
| upd_cor_pred | input | 1 | Correlated-table guess returned at lookup |

## Verification
Some properties are checked on every cycle. The final guess always equals one of the two component guesses. The history shifts in the outcome on each valid update and holds otherwise. A counter written at either end of its range stays there. Other behaviour can only be shown by the bench's scenarios against an arithmetic model: the XOR indexing and the aliasing of untagged entries, the hand-over of a branch from the simple to the correlated table, the rule that the selector moves only on disagreement, and the rule that a same-cycle lookup sees the pre-update values. The bench also shows the reset contents and the fact that inputs are ignored without `upd_valid`.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'd0;
  localparam ctr2_t CTR_WEAK_NT   = 2'd1;
  localparam ctr2_t CTR_STRONG_T  = 2'd3;

  // Saturating one-step move of a two-bit counter.
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
    ctr2_t res;
    if (up) res = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else    res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

  function automatic logic ctr_says_taken(input ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];
  ctr2_t wr_cur;
  ctr2_t wr_nxt;

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

  always_comb begin
    wr_nxt = ctr_step(wr_cur, wr_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end

  // R2: saturation at the top of the range
  assert_sat_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_cur == CTR_STRONG_T) |=> mem[$past(wr_idx)] == CTR_STRONG_T);

  // R2: saturation at the bottom of the range
  assert_sat_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_cur == CTR_STRONG_NT) |=> mem[$past(wr_idx)] == CTR_STRONG_NT);

endmodule

// File: rtl/tbp_hist_reg.sv
module tbp_hist_reg #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

  // R5: outcome enters at bit 0, older bits move up
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(shift_bit)) &&
                 (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  // R11: history holds without an update
  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BIM_IDX_W = 8,
  parameter int COR_IDX_W = 8,
  parameter int CHO_IDX_W = 8,
  parameter int HIST_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              lkp_taken,
  output logic              lkp_bim_taken,
  output logic              lkp_cor_taken,
  output logic [HIST_W-1:0] lkp_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_bim_pred,
  input  logic              upd_cor_pred
);

  localparam int PC_LSB = 2;

  logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
  logic [COR_IDX_W-1:0] cor_rd_idx, cor_wr_idx;
  logic [CHO_IDX_W-1:0] cho_rd_idx, cho_wr_idx;
  ctr2_t                bim_ctr, cor_ctr, cho_ctr;
  logic                 cho_wr_en, cho_wr_up;
  logic [HIST_W-1:0]    ghr;
  logic                 unused_pc_bits;

  assign unused_pc_bits = ^{lkp_pc, upd_pc};

  // Index formation (R3, R4, R6)
  always_comb begin
    bim_rd_idx = lkp_pc[BIM_IDX_W+PC_LSB-1:PC_LSB];
    bim_wr_idx = upd_pc[BIM_IDX_W+PC_LSB-1:PC_LSB];
    cor_rd_idx = lkp_pc[COR_IDX_W+PC_LSB-1:PC_LSB] ^ COR_IDX_W'(ghr);
    cor_wr_idx = upd_pc[COR_IDX_W+PC_LSB-1:PC_LSB] ^ COR_IDX_W'(upd_hist);
    cho_rd_idx = lkp_pc[CHO_IDX_W+PC_LSB-1:PC_LSB];
    cho_wr_idx = upd_pc[CHO_IDX_W+PC_LSB-1:PC_LSB];
  end

  // Selector training: only on disagreement, toward the component that was right (R7)
  always_comb begin
    cho_wr_en = upd_valid && (upd_bim_pred != upd_cor_pred);
    cho_wr_up = (upd_cor_pred == upd_taken);
  end

  tbp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(bim_rd_idx), .rd_ctr(bim_ctr),
    .wr_en(upd_valid), .wr_idx(bim_wr_idx), .wr_up(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(COR_IDX_W)) u_cor (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cor_rd_idx), .rd_ctr(cor_ctr),
    .wr_en(upd_valid), .wr_idx(cor_wr_idx), .wr_up(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(CHO_IDX_W)) u_cho (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cho_rd_idx), .rd_ctr(cho_ctr),
    .wr_en(cho_wr_en), .wr_idx(cho_wr_idx), .wr_up(cho_wr_up)
  );

  tbp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken), .hist(ghr)
  );

  always_comb begin
    lkp_bim_taken = ctr_says_taken(bim_ctr);
    lkp_cor_taken = ctr_says_taken(cor_ctr);
    lkp_taken     = ctr_says_taken(cho_ctr) ? lkp_cor_taken : lkp_bim_taken;
    lkp_hist      = ghr;
  end

  // R6: the final guess always comes from one of the components
  assert_final_from_component_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_taken == lkp_bim_taken) || (lkp_taken == lkp_cor_taken));

  initial begin
    assert_params_R4: assert (HIST_W >= 2 && HIST_W <= COR_IDX_W && PC_W >= PC_LSB + COR_IDX_W
                              && PC_W >= PC_LSB + BIM_IDX_W && PC_W >= PC_LSB + CHO_IDX_W);
  end

endmodule

// File: tb/tourn_bp_bench.sv
module tourn_bp_bench;

  localparam int PC_W = 16;
  localparam int IW   = 4;
  localparam int HW   = 4;
  localparam int N    = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PC_W-1:0] lkp_pc, upd_pc;
  logic          lkp_taken, lkp_bim_taken, lkp_cor_taken;
  logic [HW-1:0] lkp_hist, upd_hist;
  logic          upd_valid, upd_taken, upd_bim_pred, upd_cor_pred;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_bim [N];
  int m_cor [N];
  int m_cho [N];
  int m_ghr;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  tourn_bp #(.PC_W(PC_W), .BIM_IDX_W(IW), .COR_IDX_W(IW), .CHO_IDX_W(IW), .HIST_W(HW))
  u_tourn_bp (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .lkp_bim_taken(lkp_bim_taken), .lkp_cor_taken(lkp_cor_taken), .lkp_hist(lkp_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken),
    .upd_bim_pred(upd_bim_pred), .upd_cor_pred(upd_cor_pred)
  );

  function automatic int sat(input int v, input bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic int pidx(input logic [PC_W-1:0] pc);
    return int'(pc[IW+1:2]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One cycle: lookup pc, optionally update the same pc in the same cycle.
  task automatic step(input logic [PC_W-1:0] pc, input bit valid, input bit tk, input string req);
    int bi, ci, hi;
    bit eb, ec, ef;
    @(negedge clk);
    upd_valid = 1'b0;
    lkp_pc = pc;
    #1;
    bi = pidx(pc);
    ci = bi ^ m_ghr;
    hi = bi;
    eb = (m_bim[bi] >= 2);
    ec = (m_cor[ci] >= 2);
    ef = (m_cho[hi] >= 2) ? ec : eb;
    check(lkp_bim_taken == eb, {req, " simple guess R1 R3 R9"}, int'(lkp_bim_taken), int'(eb));
    check(lkp_cor_taken == ec, {req, " correlated guess R1 R4 R9"}, int'(lkp_cor_taken), int'(ec));
    check(lkp_taken == ef, {req, " final guess R6 R7"}, int'(lkp_taken), int'(ef));
    check(int'(lkp_hist) == m_ghr, {req, " history R5"}, int'(lkp_hist), m_ghr);
    upd_valid    = valid;
    upd_pc       = valid ? pc : ~pc;
    upd_hist     = valid ? HW'(m_ghr) : ~HW'(m_ghr);
    upd_taken    = tk;
    upd_bim_pred = eb;
    upd_cor_pred = valid ? ec : ~eb;
    @(posedge clk);
    if (valid) begin
      m_bim[bi] = sat(m_bim[bi], tk);
      m_cor[ci] = sat(m_cor[ci], tk);
      if (eb != ec) m_cho[hi] = sat(m_cho[hi], ec == tk);
      m_ghr = ((m_ghr << 1) | int'(tk)) & (N - 1);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pa, pb;
    rst_n = 1'b0;
    lkp_pc = '0; upd_pc = '0; upd_hist = '0;
    upd_valid = 1'b0; upd_taken = 1'b0; upd_bim_pred = 1'b0; upd_cor_pred = 1'b0;
    for (int i = 0; i < N; i++) begin m_bim[i] = 1; m_cor[i] = 1; m_cho[i] = 1; end
    m_ghr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset contents, every entry weakly not-taken, history clear
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      lkp_pc = PC_W'(i << 2);
      #1;
      check(!lkp_taken && !lkp_bim_taken && !lkp_cor_taken, "R8 reset guesses",
            int'({lkp_taken, lkp_bim_taken, lkp_cor_taken}), 0);
      check(lkp_hist == '0, "R8 reset history", int'(lkp_hist), 0);
    end

    // R2: push one branch to strongly taken, then one not-taken keeps taken
    pa = 16'h0010;
    for (int i = 0; i < 5; i++) step(pa, 1'b1, 1'b1, "R2 saturate up");
    step(pa, 1'b1, 1'b0, "R2 one miss");
    step(pa, 1'b1, 1'b0, "R2 second miss");
    step(pa, 1'b1, 1'b0, "R2 flipped");
    for (int i = 0; i < 5; i++) step(pa, 1'b1, 1'b0, "R2 saturate down");

    // R3: aliasing addresses share the untagged simple entry
    pb = pa + 16'h0040;
    for (int i = 0; i < 4; i++) step(pa, 1'b1, 1'b1, "R3 train alias");
    step(pb, 1'b0, 1'b0, "R3 alias observed");

    // R11: junk on update inputs without valid changes nothing
    for (int i = 0; i < 6; i++) step(PC_W'(i << 2), 1'b0, i[0], "R11 ignored update");

    // R7 R10: alternating pattern at one address hands it to the correlated side
    for (int i = 0; i < 60; i++) step(16'h0024, 1'b1, i[0], "R7 R10 alternating");

    // Sweep: pseudo-random addresses (with aliasing) and biased/periodic outcomes
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] pc;
      bit tk, v;
      adv_lfsr();
      pc = PC_W'({lfsr[6:2], 2'b00});
      case (lfsr[3:2])
        2'd0: tk = 1'b1;
        2'd1: tk = (i % 3) != 2;
        2'd2: tk = lfsr[9];
        default: tk = m_ghr[1];
      endcase
      v = (lfsr[12:10] != 3'd0);
      step(pc, v, tk, "sweep R1 R4 R5 R6 R7 R9 R10 R11");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule